// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Bit Inserter

This block sits in the transmit path of an E1 link, after the frame has been assembled and before line coding. It watches a 2.048 Mbit/s serial stream bit by bit and, in timeslot 0 of every non-align frame, can replace any of seven overhead positions: the international bit, the remote alarm bit and the five spare bits Sa4 to Sa8. The replacement value does not come from a single constant. Each position has its own 8-bit source word that holds one bit for each of the eight non-align frames of a 16-frame multiframe.

A 7-bit enable word selects the positions to override. Positions that are not enabled, align frames, the fixed bit 2 of timeslot 0 and all other timeslots are passed through unchanged. Bit position within the frame and frame number within the multiframe come from a frame pulse and a multiframe pulse. The enable word and the source words are captured together on each multiframe pulse, so a host write cannot take effect partway through a multiframe. Every output bit leaves exactly one bit clock after the matching input bit.

Top module: `e1_oh_inserter`

## Requirements
- R1: `ser_out` on the clock after an edge equals the value the block decided for the `ser_in` bit sampled at that edge. This is a fixed latency of one bit clock for every bit, including all bits of timeslots 1 to 31.
- R2: When the enable bit of an overhead position is 0, that position is passed through from `ser_in` unchanged.
- R3: When the enable bit is 1, the source bit replaces the incoming bit. The enable bits map to timeslot-0 bits (numbered 1 to 8 from the first bit of the frame) as follows: `ovr_en[6]` to bit 1 from `src_intl`, `ovr_en[5]` to bit 3 from `src_ralm`, and `ovr_en[4]` down to `ovr_en[0]` to bits 4 to 8 from `src_sa4` to `src_sa8`. Each position is enabled independently of the others.
- R4: Non-align frame 2k+1 of the multiframe (k = 0 to 7) takes bit k of each source word.
- R5: Align frames (the even frame numbers 0 to 14) are never modified.
- R6: Timeslot-0 bit 2 and every bit of timeslots 1 to 31 are never modified.
- R7: After reset, nothing is inserted until the first `mfrm_sync` pulse.
- R8: The enable word and the source words are captured on the clock where `mfrm_sync` is high. Changes made at any other time take effect only from the next multiframe pulse.
- R9: While `rst_n` is low, `ser_out` is 0 after the next clock edge.
- R10: `frm_sync` high marks timeslot-0 bit 1 of a frame. `mfrm_sync`, when high together with it, marks frame 0. Without a frame pulse, the frame position wraps after 256 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 2.048 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Incoming serial E1 data |
| frm_sync | input | 1 | High on the first bit of each frame |
| mfrm_sync | input | 1 | High on the first bit of frame 0 of a multiframe |
| ovr_en | input | 7 | Per-position override enables (mapping in R3) |
| src_intl | input | 8 | International bit source, one bit per non-align frame |
| src_ralm | input | 8 | Remote alarm bit source |
| src_sa4 | input | 8 | Sa4 source |
| src_sa5 | input | 8 | Sa5 source |
| src_sa6 | input | 8 | Sa6 source |
| src_sa7 | input | 8 | Sa7 source |
| src_sa8 | input | 8 | Sa8 source |
| ser_out | output | 1 | Modified serial stream, one bit clock later |

## Verification
The stream is driven with all-zero data and with all-one data while every position is enabled. Against a zero stream only the inserted ones show, and against a one stream only the inserted zeros show, so a stuck value or a wrong frame-to-bit mapping in the source words cannot hide. A pseudo-random stream is then run with every position disabled and with two alternating enable patterns, which shows whether each position follows only its own enable bit. Frames sent before the first multiframe pulse, and a host write made in mid-multiframe, separate the behaviour of the capture logic from that of the insertion path.

// File: rtl/e1_oh_pkg.sv
// Package: constants and helpers shared by the timeslot-0 overhead inserter.
// Field index f equals the bit of the enable word that controls the field.
package e1_oh_pkg;

    localparam int N_FIELDS = 7;
    localparam int FLD_INTL = 6;
    localparam int FLD_RALM = 5;
    localparam int FLD_SA4  = 4;
    localparam int TS0_BITS = 8;

    // Zero-based bit offset inside timeslot 0 at which field f sits.
    function automatic int unsigned field_pos(input int f);
        if (f == FLD_INTL)      return 0;
        else if (f == FLD_RALM) return 2;
        else                    return 3 + (FLD_SA4 - f);
    endfunction

endpackage

// File: rtl/e1_oh_timing.sv
// Module: e1_oh_timing
// Tracks the bit position within the frame and the frame number within the
// multiframe. The outputs are combinational and describe the bit on ser_in in
// the current cycle.
// Assumes: frm_sync marks the first bit of a frame, and mfrm_sync comes
// together with frm_sync. With no frame pulse the position wraps after
// FRAME_BITS bits.
module e1_oh_timing #(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int PW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_sync,
    input  logic          mfrm_sync,
    output logic [PW-1:0] cur_pos,
    output logic [FW-1:0] cur_frm,
    output logic          locked
);

    localparam logic [PW-1:0] POS_LAST = PW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] FRM_LAST = FW'(MF_FRAMES - 1);

    logic [PW-1:0] pos_q;
    logic [FW-1:0] frm_q;
    logic          locked_q;
    logic          pos_wrap;
    logic          frm_start;

    // Position of the current bit: restart on a frame pulse or after the last bit.
    always_comb begin
        pos_wrap  = (pos_q == POS_LAST);
        frm_start = frm_sync | pos_wrap;
        cur_pos   = frm_start ? '0 : pos_q + 1'b1;
    end

    // Frame number of the current bit: a multiframe pulse forces frame 0.
    always_comb begin
        if (mfrm_sync)
            cur_frm = '0;
        else if (frm_start)
            cur_frm = (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
        else
            cur_frm = frm_q;
    end

    // Insertion is allowed from the first multiframe pulse onward.
    assign locked = locked_q | mfrm_sync;

    // Keep the position, the frame number and the lock flag for the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= POS_LAST;
            frm_q    <= FRM_LAST;
            locked_q <= 1'b0;
        end else begin
            pos_q    <= cur_pos;
            frm_q    <= cur_frm;
            locked_q <= locked;
        end
    end

endmodule

// File: rtl/e1_oh_shadow.sv
// Module: e1_oh_shadow
// Holds the enable word and the per-field source words, loaded together on a
// load pulse (the multiframe pulse), so that the insertion logic sees one
// consistent set for a whole multiframe.
// Assumes: the host inputs are stable around the clock edge of the load pulse.
module e1_oh_shadow #(
    parameter int N_FIELDS = 7,
    parameter int SRC_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [N_FIELDS-1:0]            en_in,
    input  logic [N_FIELDS-1:0][SRC_W-1:0] src_in,
    output logic [N_FIELDS-1:0]            en_q,
    output logic [N_FIELDS-1:0][SRC_W-1:0] src_q
);

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
        // Capture the enable and source word of field f on a load pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[f]  <= 1'b0;
                src_q[f] <= '0;
            end else if (load) begin
                en_q[f]  <= en_in[f];
                src_q[f] <= src_in[f];
            end
        end
    end

endmodule

// File: rtl/e1_oh_select.sv
// Module: e1_oh_select
// Decides for the current bit whether an overhead field overrides it, and
// with which value. This module is purely combinational.
// Assumes: cur_pos and cur_frm describe the bit now on ser_in. Odd frame
// numbers are non-align frames.
module e1_oh_select
    import e1_oh_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int PW    = $clog2(FRAME_BITS),
    localparam int FW    = $clog2(MF_FRAMES),
    localparam int SRC_W = MF_FRAMES / 2
) (
    input  logic [PW-1:0]                  cur_pos,
    input  logic [FW-1:0]                  cur_frm,
    input  logic                           locked,
    input  logic [N_FIELDS-1:0]            en,
    input  logic [N_FIELDS-1:0][SRC_W-1:0] src,
    output logic [N_FIELDS-1:0]            hit,
    output logic                           ovr_active,
    output logic                           ovr_bit
);

    logic          in_naf;
    logic [FW-2:0] slot;
    logic [N_FIELDS-1:0] val;

    // A non-align frame after lock is the only place an override can occur.
    assign in_naf = locked & cur_frm[0];
    // Non-align frame 2k+1 takes source bit k.
    assign slot   = cur_frm[FW-1:1];

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
        localparam logic [PW-1:0] FPOS = PW'(field_pos(f));
        // Field f claims the bit when it is enabled and the position matches.
        assign hit[f] = in_naf & en[f] & (cur_pos == FPOS);
        // Source bit of field f for this frame.
        assign val[f] = src[f][slot];
    end

    // Combine the fields: at most one of them claims any given bit.
    assign ovr_active = |hit;
    assign ovr_bit    = |(hit & val);

endmodule

// File: rtl/e1_oh_inserter.sv
// Module: e1_oh_inserter (top)
// Overrides the selected overhead bits of timeslot 0 in E1 non-align frames
// with values taken from per-frame source words, and passes every other bit
// through. The output is registered, which gives one bit clock of latency.
// Assumes: a bit clock at the line rate and a synchronous active-low reset.
module e1_oh_inserter
    import e1_oh_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int PW    = $clog2(FRAME_BITS),
    localparam int FW    = $clog2(MF_FRAMES),
    localparam int SRC_W = MF_FRAMES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             frm_sync,
    input  logic             mfrm_sync,
    input  logic [6:0]       ovr_en,
    input  logic [SRC_W-1:0] src_intl,
    input  logic [SRC_W-1:0] src_ralm,
    input  logic [SRC_W-1:0] src_sa4,
    input  logic [SRC_W-1:0] src_sa5,
    input  logic [SRC_W-1:0] src_sa6,
    input  logic [SRC_W-1:0] src_sa7,
    input  logic [SRC_W-1:0] src_sa8,
    output logic             ser_out
);

    logic [N_FIELDS-1:0][SRC_W-1:0] src_arr;
    logic [N_FIELDS-1:0][SRC_W-1:0] src_shadow;
    logic [N_FIELDS-1:0]            en_shadow;
    logic [N_FIELDS-1:0]            fld_hit;
    logic [PW-1:0]                  cur_pos;
    logic [FW-1:0]                  cur_frm;
    logic                           locked;
    logic                           ovr_active;
    logic                           ovr_bit;

    // Pack the source words so that index f matches enable bit f.
    assign src_arr = {src_intl, src_ralm, src_sa4, src_sa5, src_sa6, src_sa7, src_sa8};

    e1_oh_timing #(
        .FRAME_BITS (FRAME_BITS),
        .MF_FRAMES  (MF_FRAMES)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_sync  (frm_sync),
        .mfrm_sync (mfrm_sync),
        .cur_pos   (cur_pos),
        .cur_frm   (cur_frm),
        .locked    (locked)
    );

    e1_oh_shadow #(
        .N_FIELDS (N_FIELDS),
        .SRC_W    (SRC_W)
    ) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mfrm_sync),
        .en_in  (ovr_en),
        .src_in (src_arr),
        .en_q   (en_shadow),
        .src_q  (src_shadow)
    );

    e1_oh_select #(
        .FRAME_BITS (FRAME_BITS),
        .MF_FRAMES  (MF_FRAMES)
    ) u_select (
        .cur_pos    (cur_pos),
        .cur_frm    (cur_frm),
        .locked     (locked),
        .en         (en_shadow),
        .src        (src_shadow),
        .hit        (fld_hit),
        .ovr_active (ovr_active),
        .ovr_bit    (ovr_bit)
    );

    // Output register: the override value or the incoming bit, one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_out <= 1'b0;
        else
            ser_out <= ovr_active ? ovr_bit : ser_in;
    end

endmodule

// File: rtl/e1_oh_inserter_chk.sv
// Module: e1_oh_inserter_chk
// Checks timing properties of the inserter. It is attached to the top module
// with the bind statement at the end of this file.
module e1_oh_inserter_chk
    import e1_oh_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int PW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_in,
    input logic                ser_out,
    input logic                mfrm_sync,
    input logic [PW-1:0]       cur_pos,
    input logic [FW-1:0]       cur_frm,
    input logic                locked,
    input logic [N_FIELDS-1:0] fld_hit,
    input logic                ovr_active,
    input logic                ovr_bit,
    input logic [N_FIELDS-1:0] en_shadow
);

    localparam logic [PW-1:0] TS0_END = PW'(TS0_BITS);
    localparam logic [PW-1:0] POS_B2  = PW'(1);

    // R1/R2: a bit that is not overridden leaves unchanged one clock later.
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_active |=> ser_out == $past(ser_in));

    // R3: an overridden bit leaves as the chosen source value.
    a_r3_replace: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_active |=> ser_out == $past(ovr_bit));

    // R3: no two fields ever claim the same bit.
    a_r3_single_field: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fld_hit));

    // R5: align frames are never touched.
    a_r5_align_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_frm[0] |-> !ovr_active);

    // R6: only timeslot 0, and never its bit 2.
    a_r6_ts0_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pos >= TS0_END || cur_pos == POS_B2) |-> !ovr_active);

    // R7: no insertion before the first multiframe pulse.
    a_r7_hold_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !ovr_active);

    // R8: the captured enables change only after a multiframe pulse.
    a_r8_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mfrm_sync |=> $stable(en_shadow));

endmodule

bind e1_oh_inserter e1_oh_inserter_chk #(
    .FRAME_BITS (FRAME_BITS),
    .MF_FRAMES  (MF_FRAMES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .mfrm_sync  (mfrm_sync),
    .cur_pos    (cur_pos),
    .cur_frm    (cur_frm),
    .locked     (locked),
    .fld_hit    (fld_hit),
    .ovr_active (ovr_active),
    .ovr_bit    (ovr_bit),
    .en_shadow  (en_shadow)
);

// File: tb/e1_oh_inserter_test.sv
// Scoreboard bench: the driver computes the expected output bit of every
// input bit from the requirements and queues it. The monitor pops one item
// after each clock edge and compares it with ser_out.
module e1_oh_inserter_test;

    localparam int CLK_P      = 10;
    localparam int FRAME_BITS = 256;
    localparam int MF_FRAMES  = 16;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic frm_sync = 1'b0;
    logic mfrm_sync = 1'b0;
    logic [6:0] ovr_en = '0;
    logic [6:0][7:0] host_src = '0;
    logic ser_out;

    logic [6:0]      snap_en = '0;
    logic [6:0][7:0] snap_src = '0;
    bit              m_locked = 1'b0;
    bit              after_write = 1'b0;
    logic [15:0]     lfsr = 16'hACE1;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    e1_oh_inserter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .frm_sync  (frm_sync),
        .mfrm_sync (mfrm_sync),
        .ovr_en    (ovr_en),
        .src_intl  (host_src[6]),
        .src_ralm  (host_src[5]),
        .src_sa4   (host_src[4]),
        .src_sa5   (host_src[3]),
        .src_sa6   (host_src[2]),
        .src_sa7   (host_src[1]),
        .src_sa8   (host_src[0]),
        .ser_out   (ser_out)
    );

    // Enable index of the field at a zero-based timeslot-0 offset (R3), or -1.
    function automatic int field_at(input int pos);
        case (pos)
            0: return 6;
            2: return 5;
            3: return 4;
            4: return 3;
            5: return 2;
            6: return 1;
            7: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic logic next_data(input int pat);
        if (pat == 0) return 1'b0;
        if (pat == 1) return 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Drive one bit and queue the output expected for it.
    task automatic drive_bit(input logic d, input int fr, input int pos, input bit ms);
        exp_t e;
        int f;
        @(negedge clk);
        ser_in    = d;
        frm_sync  = (pos == 0);
        mfrm_sync = ms;
        if (ms) begin
            snap_en     = ovr_en;
            snap_src    = host_src;
            m_locked    = 1'b1;
            after_write = 1'b0;
        end
        e.b = d;
        f = field_at(pos);
        if (!m_locked)            e.tag = "R7";
        else if (pos >= 8)        e.tag = "R1";
        else if (fr % 2 == 0)     e.tag = "R5";
        else if (f < 0)           e.tag = "R6";
        else if (!snap_en[f])     e.tag = "R2";
        else begin
            e.b = snap_src[f][fr/2];
            e.tag = after_write ? "R8" : ((fr > 1) ? "R4" : "R3");
        end
        sbq.push_back(e);
    endtask

    // One multiframe (or plain frames when mf is 0). When wr_frame >= 0, the
    // host writes the new enables and inverted sources inside that frame.
    task automatic run_mf(input int pat, input bit mf, input int nfr,
                          input int wr_frame, input logic [6:0] wr_en);
        for (int fr = 0; fr < nfr; fr++) begin
            for (int pos = 0; pos < FRAME_BITS; pos++) begin
                drive_bit(next_data(pat), fr, pos, mf && fr == 0 && pos == 0);
                if (fr == wr_frame && pos == 100) begin
                    ovr_en      = wr_en;
                    host_src    = ~host_src;
                    after_write = 1'b1;
                end
            end
        end
    endtask

    // Monitor: compare ser_out just after each edge with the oldest queued item.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (ser_out !== e.b) begin
                failures++;
                $display("FAIL %s ser_out actual=%0b expected=%0b", e.tag, ser_out, e.b);
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset clears the output even with ones on the input.
        ser_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (ser_out !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset ser_out actual=%0b expected=0", ser_out);
        end
        rst_n = 1'b1;

        // R7/R10: frame pulses only, everything enabled, no insertion yet.
        ovr_en   = 7'h7F;
        host_src = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_mf(0, 1'b0, 2, -1, '0);

        // R3/R4: distinct patterns per field on zero data, then on one data.
        host_src = {8'hA5, 8'h3C, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h96};
        run_mf(0, 1'b1, MF_FRAMES, -1, '0);
        run_mf(1, 1'b1, MF_FRAMES, -1, '0);

        // R2: all disabled on random data.
        ovr_en = 7'h00;
        run_mf(2, 1'b1, MF_FRAMES, -1, '0);

        // R3 independence: alternating enable patterns.
        ovr_en = 7'b0101010;
        run_mf(0, 1'b1, MF_FRAMES, -1, '0);
        ovr_en = 7'b1010101;
        run_mf(1, 1'b1, MF_FRAMES, -1, '0);

        // R8: a write in mid-multiframe waits for the next multiframe pulse.
        ovr_en = 7'h7F;
        run_mf(0, 1'b1, MF_FRAMES, 7, 7'h00);
        run_mf(0, 1'b1, MF_FRAMES, -1, '0);
        ovr_en = 7'h7F;
        run_mf(1, 1'b1, MF_FRAMES, 3, 7'b0011100);
        run_mf(2, 1'b1, MF_FRAMES, -1, '0);

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule